// File: doc/BRIEF.md
# Lockable Cache Tag Controller

This block keeps the tags, valid bits and replacement state of a small four-way set-associative cache, and decides for each lookup whether it hits and, on a miss, what kind of bus fill to request. Tags and valid bits sit in flops, so a whole-cache invalidate completes in one clock. The data array, the bus side and write-back of modified lines are handled elsewhere. The controller only issues the fill request and waits for a refill-done pulse.

A control register holds four bits: cache enable, lock, flash invalidate and touch disable. With lock set, resident lines still hit. A miss then becomes a non-allocating single-beat fill, so the cache contents are frozen. Snoop invalidates are honoured at all times. A line removed by a snoop while lock is set therefore stays absent until lock is cleared. The flash-invalidate bit clears every line and resets replacement state. It then clears itself, but only while the cache is enabled. With touch disable set, lookups tagged as touch hints have no effect.

Top module: `lockable_tag_ctrl`

## Requirements
- R1: After reset no line is valid, all replacement state points at way 0, ctrl_o reads 0 (bit 0 enable, bit 1 lock, bit 2 flash, bit 3 touch disable), and fill_req_o and busy_o are low.
- R2: A qualified lookup of a resident line raises hit_o and gives the matching way on hit_way_o in the same cycle, whether lock is set or clear.
- R3: With lock clear, a qualified lookup that misses raises miss_o in the same cycle. From the next cycle it holds fill_req_o with fill_single_o low and a line-aligned fill_addr_o (offset bits zero) until the cycle where refill_done_i is sampled high. That edge writes the victim way with the tag and marks it valid.
- R4: Each set keeps three replacement bits. b0 selects the pair: 0 selects ways 0/1 and 1 selects ways 2/3. b1 picks way 0 (0) or way 1 (1), and b2 picks way 2 (0) or way 3 (1). The victim is the way these bits point to. A hit or an allocation to way w sets the bits to point away from w.
- R5: With lock set, a miss requests a fill with fill_single_o high and the full unaligned address, and allocates no line on refill-done.
- R6: A snoop invalidate (sn_valid_i, line address sn_line_i) clears the matching line whether lock is set or not. A lookup to the same line in the same cycle misses.
- R7: While lock stays set, a line removed by a snoop keeps missing. After lock is cleared, a miss to it allocates again.
- R8: Writing the flash bit with enable set raises busy_o for exactly the next cycle. At the end of that cycle every valid bit clears, all replacement state returns to way 0 and the flash bit of ctrl_o clears.
- R9: Writing the flash bit with enable clear leaves the flash bit set, keeps busy_o low and leaves the lines in place.
- R10: While busy_o is high (flash cycle or fill outstanding), a qualified lookup reads as a miss, never a hit, and starts no fill.
- R11: With touch disable set, a lookup with lk_touch_i high produces neither hit_o nor miss_o, requests no fill and leaves replacement state unchanged.
- R12: With enable clear, lookups produce neither hit_o nor miss_o and request no fill.
- R13: fill_write_o carries the lk_write_i value of the lookup that started the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | ADDR_W | Lookup byte address |
| lk_write_i | input | 1 | Lookup is a store |
| lk_touch_i | input | 1 | Lookup is a touch hint |
| sn_valid_i | input | 1 | Snoop invalidate request |
| sn_line_i | input | ADDR_W-OFF_W | Snooped line address |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_enable_i | input | 1 | Written enable bit |
| cfg_lock_i | input | 1 | Written lock bit |
| cfg_flash_i | input | 1 | Written flash-invalidate bit |
| cfg_touch_off_i | input | 1 | Written touch-disable bit |
| refill_done_i | input | 1 | Bus fill finished |
| ctrl_o | output | 4 | Control register readback |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup miss |
| hit_way_o | output | 2 | Way that hit |
| fill_req_o | output | 1 | Fill request outstanding |
| fill_single_o | output | 1 | Fill is single-beat, non-allocating |
| fill_addr_o | output | ADDR_W | Fill address |
| fill_write_o | output | 1 | Fill was started by a store |
| busy_o | output | 1 | Flash invalidate or fill in progress |

## Verification
The bench aims at the mode edges: a miss under lock, which a faulty design would let allocate so that the repeat lookup hits; a snoop that lands in the same cycle as a lookup of that line, which a design applying the snoop late would report as a hit; and a snooped line under lock, which must keep missing until unlock. It walks a set through all four allocations to pin down the replacement order, and checks after a flash that the next allocation lands in way 0. It writes the flash bit with the cache disabled and expects the bit to stay set and the lines to survive, catching a design that clears it unconditionally. Touch lookups with touch disable set, and lookups made while busy, must leave both the outputs and the later victim choice undisturbed.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int unsigned WAYS  = 4;
  localparam int unsigned WAY_W = 2;

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [2:0]       plru_t;

  typedef enum logic {FILL_IDLE, FILL_WAIT} fill_state_e;

  // b0 picks the pair, b1 inside ways 0/1, b2 inside ways 2/3
  function automatic way_t plru_victim(plru_t s);
    return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
  endfunction

  function automatic plru_t plru_point_away(plru_t s, way_t w);
    plru_t n;
    n    = s;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/ctc_tag_store.sv
module ctc_tag_store
  import ctc_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flash_i,
  input  logic             sn_valid_i,
  input  logic [IDX_W-1:0] sn_idx_i,
  input  logic [TAG_W-1:0] sn_tag_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  way_t             wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic             lk_hit_o,
  output way_t             lk_way_o
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  sn_kill, lk_match;
  logic             same_set;

  assign same_set = sn_idx_i == lk_idx_i;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign sn_kill[w]  = sn_valid_i && valid_q[sn_idx_i][w] &&
                         (tag_q[sn_idx_i][w] == sn_tag_i);
    // snoop takes effect before a same-cycle lookup
    assign lk_match[w] = valid_q[lk_idx_i][w] && !(sn_kill[w] && same_set) &&
                         (tag_q[lk_idx_i][w] == lk_tag_i);
  end

  always_comb begin
    lk_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_match[w]) lk_way_o = way_t'(w);
  end
  assign lk_hit_o = |lk_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (flash_i) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (|sn_kill) valid_q[sn_idx_i] <= valid_q[sn_idx_i] & ~sn_kill;
      if (wr_en_i)  valid_q[wr_idx_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i][wr_way_i] <= wr_tag_i;
  end
endmodule

// File: rtl/ctc_plru_bank.sv
module ctc_plru_bank
  import ctc_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flash_i,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  way_t             upd_way_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output way_t             victim_o
);
  plru_t st_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              st_q[s] <= '0;
      else if (flash_i)                         st_q[s] <= '0;
      else if (upd_i && upd_idx_i == IDX_W'(s)) st_q[s] <= plru_point_away(st_q[s], upd_way_i);
    end
  end

  assign victim_o = plru_victim(st_q[rd_idx_i]);
endmodule

// File: rtl/ctc_fill_ctrl.sv
module ctc_fill_ctrl
  import ctc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              single_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  way_t              victim_i,
  input  logic              refill_done_i,
  output logic              fill_req_o,
  output logic              fill_single_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic              fill_write_o,
  output logic              alloc_o,
  output way_t              alloc_way_o
);
  fill_state_e       state_q;
  logic              single_q, write_q;
  logic [ADDR_W-1:0] addr_q;
  way_t              way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= FILL_IDLE;
      single_q <= 1'b0;
      write_q  <= 1'b0;
      addr_q   <= '0;
      way_q    <= '0;
    end else begin
      case (state_q)
        FILL_IDLE: if (start_i) begin
          state_q  <= FILL_WAIT;
          single_q <= single_i;
          write_q  <= write_i;
          way_q    <= victim_i;
          addr_q   <= single_i ? addr_i : {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
        FILL_WAIT: if (refill_done_i) state_q <= FILL_IDLE;
        default:   state_q <= FILL_IDLE;
      endcase
    end
  end

  assign fill_req_o    = state_q == FILL_WAIT;
  assign fill_single_o = single_q;
  assign fill_addr_o   = addr_q;
  assign fill_write_o  = write_q;
  assign alloc_o       = fill_req_o && refill_done_i && !single_q;
  assign alloc_way_o   = way_q;
endmodule

// File: rtl/lockable_tag_ctrl.sv
module lockable_tag_ctrl
  import ctc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 16,
  parameter int unsigned OFF_W  = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lk_valid_i,
  input  logic [ADDR_W-1:0]       lk_addr_i,
  input  logic                    lk_write_i,
  input  logic                    lk_touch_i,
  input  logic                    sn_valid_i,
  input  logic [ADDR_W-OFF_W-1:0] sn_line_i,
  input  logic                    cfg_we_i,
  input  logic                    cfg_enable_i,
  input  logic                    cfg_lock_i,
  input  logic                    cfg_flash_i,
  input  logic                    cfg_touch_off_i,
  input  logic                    refill_done_i,
  output logic [3:0]              ctrl_o,
  output logic                    hit_o,
  output logic                    miss_o,
  output logic [1:0]              hit_way_o,
  output logic                    fill_req_o,
  output logic                    fill_single_o,
  output logic [ADDR_W-1:0]       fill_addr_o,
  output logic                    fill_write_o,
  output logic                    busy_o
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  logic en_q, lock_q, flash_q, toff_q;
  logic flash_now, act, lk_hit, miss_go, alloc, upd;
  way_t lk_way, victim, alloc_way, upd_way;
  logic [IDX_W-1:0] lk_idx, sn_idx, fill_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, sn_tag, fill_tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      lock_q  <= 1'b0;
      flash_q <= 1'b0;
      toff_q  <= 1'b0;
    end else if (cfg_we_i) begin
      en_q    <= cfg_enable_i;
      lock_q  <= cfg_lock_i;
      flash_q <= cfg_flash_i;
      toff_q  <= cfg_touch_off_i;
    end else if (flash_q && en_q) begin
      flash_q <= 1'b0;
    end
  end

  assign ctrl_o    = {toff_q, flash_q, lock_q, en_q};
  assign flash_now = flash_q && en_q;
  assign busy_o    = flash_now || fill_req_o;

  assign lk_idx = lk_addr_i[OFF_W +: IDX_W];
  assign lk_tag = lk_addr_i[ADDR_W-1 -: TAG_W];
  assign sn_idx = sn_line_i[IDX_W-1:0];
  assign sn_tag = sn_line_i[ADDR_W-OFF_W-1 -: TAG_W];
  assign fill_idx = fill_addr_o[OFF_W +: IDX_W];
  assign fill_tag = fill_addr_o[ADDR_W-1 -: TAG_W];

  assign act       = lk_valid_i && en_q && !(lk_touch_i && toff_q);
  assign hit_o     = act && !busy_o && lk_hit;
  assign miss_o    = act && (busy_o || !lk_hit);
  assign hit_way_o = hit_o ? lk_way : '0;
  assign miss_go   = act && !busy_o && !lk_hit;

  // hit and allocation never coincide: hits need an idle fill path
  assign upd     = hit_o || alloc;
  assign upd_idx = alloc ? fill_idx : lk_idx;
  assign upd_way = alloc ? alloc_way : lk_way;

  ctc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .flash_i    (flash_now),
    .sn_valid_i,
    .sn_idx_i   (sn_idx),
    .sn_tag_i   (sn_tag),
    .lk_idx_i   (lk_idx),
    .lk_tag_i   (lk_tag),
    .wr_en_i    (alloc),
    .wr_idx_i   (fill_idx),
    .wr_way_i   (alloc_way),
    .wr_tag_i   (fill_tag),
    .lk_hit_o   (lk_hit),
    .lk_way_o   (lk_way)
  );

  ctc_plru_bank #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
    .clk_i, .rst_ni,
    .flash_i   (flash_now),
    .upd_i     (upd),
    .upd_idx_i (upd_idx),
    .upd_way_i (upd_way),
    .rd_idx_i  (lk_idx),
    .victim_o  (victim)
  );

  ctc_fill_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fill (
    .clk_i, .rst_ni,
    .start_i       (miss_go),
    .single_i      (lock_q),
    .addr_i        (lk_addr_i),
    .write_i       (lk_write_i),
    .victim_i      (victim),
    .refill_done_i,
    .fill_req_o,
    .fill_single_o,
    .fill_addr_o,
    .fill_write_o,
    .alloc_o       (alloc),
    .alloc_way_o   (alloc_way)
  );
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              lk_valid_i,
  input logic              lk_touch_i,
  input logic              refill_done_i,
  input logic [3:0]        ctrl_o,
  input logic              hit_o,
  input logic              miss_o,
  input logic              busy_o,
  input logic              fill_req_o,
  input logic              fill_single_o,
  input logic [ADDR_W-1:0] fill_addr_o
);
  a_r8_flash_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[2] && ctrl_o[0] && !cfg_we_i) |=> !ctrl_o[2]);

  a_r9_flash_held_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[2] && !ctrl_o[0] && !cfg_we_i) |=> ctrl_o[2]);

  a_r10_busy_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !hit_o);

  a_r2_hit_miss_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  a_r5_locked_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fill_req_o) && $past(ctrl_o[1])) |-> fill_single_o);

  a_r3_fill_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !refill_done_i) |=> (fill_req_o && $stable(fill_addr_o)));

  a_r11_touch_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_touch_i && ctrl_o[3]) |-> (!hit_o && !miss_o));

  a_r12_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[0] |-> (!hit_o && !miss_o));
endmodule

bind lockable_tag_ctrl ctc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .lk_valid_i    (lk_valid_i),
  .lk_touch_i    (lk_touch_i),
  .refill_done_i (refill_done_i),
  .ctrl_o        (ctrl_o),
  .hit_o         (hit_o),
  .miss_o        (miss_o),
  .busy_o        (busy_o),
  .fill_req_o    (fill_req_o),
  .fill_single_o (fill_single_o),
  .fill_addr_o   (fill_addr_o)
);

// File: tb/sim_lockable_tag_ctrl.sv
`timescale 1ns/1ps
module sim_lockable_tag_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, lk_touch = 0, sn_valid = 0;
  logic [31:0] lk_addr = '0;
  logic [26:0] sn_line = '0;
  logic cfg_we = 0, cfg_en = 0, cfg_lock = 0, cfg_flash = 0, cfg_toff = 0;
  logic refill_done = 0;
  logic [3:0] ctrl_o;
  logic hit_o, miss_o, fill_req_o, fill_single_o, fill_write_o, busy_o;
  logic [1:0] hit_way_o;
  logic [31:0] fill_addr_o;

  always #2.5 clk = ~clk;

  lockable_tag_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(lk_valid), .lk_addr_i(lk_addr),
    .lk_write_i(lk_write), .lk_touch_i(lk_touch), .sn_valid_i(sn_valid),
    .sn_line_i(sn_line), .cfg_we_i(cfg_we), .cfg_enable_i(cfg_en),
    .cfg_lock_i(cfg_lock), .cfg_flash_i(cfg_flash), .cfg_touch_off_i(cfg_toff),
    .refill_done_i(refill_done), .ctrl_o(ctrl_o), .hit_o(hit_o), .miss_o(miss_o),
    .hit_way_o(hit_way_o), .fill_req_o(fill_req_o), .fill_single_o(fill_single_o),
    .fill_addr_o(fill_addr_o), .fill_write_o(fill_write_o), .busy_o(busy_o)
  );

  int n_chk = 0, n_err = 0;
  logic [22:0] m_tag [16][4];
  bit          m_val [16][4];
  logic [2:0]  m_pl  [16];
  bit m_en, m_lock, m_flash, m_toff;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [1:0] vict(logic [2:0] s);
    if (s[0]) return s[2] ? 2'd3 : 2'd2;
    return s[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [2:0] away(logic [2:0] s, logic [1:0] w);
    logic [2:0] n = s;
    case (w)
      2'd0: begin n[0] = 1; n[1] = 1; end
      2'd1: begin n[0] = 1; n[1] = 0; end
      2'd2: begin n[0] = 0; n[2] = 1; end
      default: begin n[0] = 0; n[2] = 0; end
    endcase
    return n;
  endfunction

  function automatic int find(int idx, logic [22:0] tg);
    for (int w = 0; w < 4; w++) if (m_val[idx][w] && m_tag[idx][w] == tg) return w;
    return -1;
  endfunction

  function automatic logic [31:0] mk(int tg, int idx, int off);
    return {23'(tg), 4'(idx), 5'(off)};
  endfunction

  task automatic snoop_model(input logic [26:0] sl);
    int w;
    w = find(int'(sl[3:0]), sl[26:4]);
    if (w >= 0) m_val[sl[3:0]][w] = 0;
  endtask

  task automatic model_flash();
    for (int s = 0; s < 16; s++) begin
      m_pl[s] = 0;
      for (int w = 0; w < 4; w++) m_val[s][w] = 0;
    end
  endtask

  task automatic lookup(input logic [31:0] a, input bit wr, input bit tch,
                        input bit sn, input logic [26:0] sl, input string rq);
    int idx, w;
    logic [22:0] tg;
    bit act, eh, em, sg;
    logic [1:0] v;
    idx = int'(a[8:5]); tg = a[31:9];
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_write = wr; lk_touch = tch;
    sn_valid = sn; sn_line = sl;
    if (sn) snoop_model(sl);
    w  = find(idx, tg);
    act = m_en && !(tch && m_toff);
    eh = act && w >= 0;
    em = act && w < 0;
    #1;
    chk(hit_o == eh, {rq, " hit"}, hit_o, eh);
    chk(miss_o == em, {rq, " miss"}, miss_o, em);
    if (eh) chk(hit_way_o == 2'(w), "R4 hit way", hit_way_o, w);
    v = vict(m_pl[idx]); sg = m_lock;
    @(posedge clk);
    if (eh) m_pl[idx] = away(m_pl[idx], 2'(w));
    @(negedge clk);
    lk_valid = 0; sn_valid = 0;
    #1;
    if (!em) begin
      chk(fill_req_o == 0, {rq, " no fill"}, fill_req_o, 0);
    end else begin
      chk(fill_req_o == 1, "R3 fill request", fill_req_o, 1);
      chk(fill_single_o == sg, "R5 single-beat flag", fill_single_o, sg);
      chk(fill_addr_o == (sg ? a : {a[31:5], 5'd0}), "R3 fill address", fill_addr_o,
          sg ? a : {a[31:5], 5'd0});
      chk(fill_write_o == wr, "R13 fill write", fill_write_o, wr);
      chk(busy_o == 1, "R10 busy during fill", busy_o, 1);
      lk_valid = 1; lk_addr = a; lk_touch = 0;
      repeat ($urandom % 3) @(posedge clk);
      #0.5;
      chk(miss_o && !hit_o, "R10 lookup while busy", {hit_o, miss_o}, 2'b01);
      refill_done = 1;
      @(posedge clk);
      @(negedge clk);
      lk_valid = 0; refill_done = 0;
      if (!sg) begin
        m_tag[idx][v] = tg; m_val[idx][v] = 1; m_pl[idx] = away(m_pl[idx], v);
      end
      #1;
      chk(fill_req_o == 0, "R3 fill released", fill_req_o, 0);
      chk(busy_o == 0, "R3 busy released", busy_o, 0);
    end
  endtask

  task automatic snoop(input logic [26:0] sl);
    @(negedge clk);
    sn_valid = 1; sn_line = sl;
    snoop_model(sl);
    @(negedge clk);
    sn_valid = 0;
  endtask

  task automatic cfg(input bit en, input bit lk, input bit fl, input bit to, input logic [31:0] probe);
    @(negedge clk);
    cfg_we = 1; cfg_en = en; cfg_lock = lk; cfg_flash = fl; cfg_toff = to;
    @(negedge clk);
    cfg_we = 0;
    m_en = en; m_lock = lk; m_flash = fl; m_toff = to;
    #1;
    chk(ctrl_o == {to, fl, lk, en}, "R8 control readback", ctrl_o, {to, fl, lk, en});
    if (fl && en) begin
      chk(busy_o == 1, "R8 busy in flash cycle", busy_o, 1);
      lk_valid = 1; lk_addr = probe; lk_touch = 0; lk_write = 0;
      #0.5;
      chk(miss_o && !hit_o, "R10 lookup during flash", {hit_o, miss_o}, 2'b01);
      @(posedge clk);
      model_flash();
      @(negedge clk);
      lk_valid = 0;
      m_flash = 0;
      #1;
      chk(busy_o == 0, "R8 busy one cycle", busy_o, 0);
      chk(ctrl_o[2] == 0, "R8 flash self-clear", ctrl_o[2], 0);
      chk(fill_req_o == 0, "R10 no fill from flash probe", fill_req_o, 0);
    end else begin
      chk(busy_o == 0, "R9 no busy", busy_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_en = 0; m_lock = 0; m_flash = 0; m_toff = 0;
    model_flash();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(ctrl_o == 0, "R1 control reset", ctrl_o, 0);
    chk(fill_req_o == 0 && busy_o == 0, "R1 idle after reset", {fill_req_o, busy_o}, 0);
    chk(hit_o == 0 && miss_o == 0, "R1 no lookup result", {hit_o, miss_o}, 0);

    cfg(1, 0, 0, 0, 0);
    lookup(mk(1, 1, 0), 0, 0, 0, 0, "R3");
    lookup(mk(2, 1, 4), 1, 0, 0, 0, "R3");
    lookup(mk(3, 1, 0), 0, 0, 0, 0, "R3");
    lookup(mk(4, 1, 0), 1, 0, 0, 0, "R3");
    chk(find(1, 23'd1) == 0 && find(1, 23'd2) == 2 && find(1, 23'd3) == 1 && find(1, 23'd4) == 3,
        "R4 fill order", 0, 0);
    lookup(mk(1, 1, 8), 0, 0, 0, 0, "R2");
    lookup(mk(4, 1, 8), 0, 0, 0, 0, "R2");

    cfg(1, 1, 0, 0, 0);
    lookup(mk(2, 1, 0), 0, 0, 0, 0, "R2");
    lookup(mk(7, 1, 3), 1, 0, 0, 0, "R5");
    lookup(mk(7, 1, 3), 0, 0, 0, 0, "R5");
    snoop(mk(3, 1, 0) >> 5);
    lookup(mk(3, 1, 0), 0, 0, 0, 0, "R7");
    lookup(mk(3, 1, 0), 0, 0, 0, 0, "R7");
    lookup(mk(4, 1, 0), 0, 0, 1, mk(4, 1, 0) >> 5, "R6");
    cfg(1, 0, 0, 0, 0);
    lookup(mk(3, 1, 0), 0, 0, 0, 0, "R7");
    lookup(mk(3, 1, 0), 0, 0, 0, 0, "R7");
    lookup(mk(2, 1, 0), 0, 0, 1, mk(2, 1, 0) >> 5, "R6");

    cfg(1, 0, 0, 1, 0);
    lookup(mk(9, 2, 0), 0, 1, 0, 0, "R11");
    lookup(mk(3, 1, 0), 0, 1, 0, 0, "R11");
    cfg(1, 0, 0, 0, 0);

    cfg(1, 0, 1, 0, mk(3, 1, 0));
    lookup(mk(3, 1, 0), 0, 0, 0, 0, "R8");
    chk(find(1, 23'd3) == 0, "R8 first fill after flash in way 0", find(1, 23'd3), 0);
    lookup(mk(3, 1, 0), 0, 0, 0, 0, "R8");

    cfg(0, 0, 1, 0, 0);
    repeat (3) begin
      @(negedge clk); #1;
      chk(ctrl_o[2] == 1 && busy_o == 0, "R9 flash held while disabled", {ctrl_o[2], busy_o}, 2'b10);
    end
    lookup(mk(3, 1, 0), 0, 0, 0, 0, "R12");
    lookup(mk(11, 5, 0), 0, 0, 0, 0, "R12");
    cfg(1, 0, 0, 0, 0);
    lookup(mk(3, 1, 0), 0, 0, 0, 0, "R9");

    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] a;
      op = int'($urandom % 12);
      a  = mk(int'($urandom % 5), int'($urandom % 3), int'($urandom % 32));
      if (op < 7)
        lookup(a, 1'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0,
               mk(int'($urandom % 5), int'($urandom % 3), 0) >> 5, "R2");
      else if (op == 7 || op == 8) snoop(a >> 5);
      else if (op == 9)  cfg(1, ~m_lock, 0, m_toff, 0);
      else if (op == 10) cfg(1, m_lock, 0, ~m_toff, 0);
      else if (($urandom % 4) == 0) cfg(1, m_lock, 1, m_toff, a);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule